// File: doc/BRIEF.md
# Nine-bit serial panel register receiver

This block is the panel-side receiver of a nine-bit serial control link. A host shifts nine-bit words in, most significant bit first, on a clock that idles high. Each word is sampled on the rising clock edge while the active-low select is held low. Bit 8 of each word says what kind of word it is. When it is 0 the word is a command. When it is 1 the word is a data byte for the most recent command.

A command in the window 0xB0 to 0xED selects one register of a small register file. The data bytes that follow fill that register. A two-byte register takes its high byte first. Four bare commands control the panel state: one pair enters and leaves sleep, and the other pair turns the display on and off.

The serial pins are resampled in the system clock domain through two-flop synchronisers. The system clock must run at least four times faster than the serial clock. The register contents, the sleep and display flags, and a sticky framing-error flag come out as plain levels.

Top module: `spi9_panel_regs`

## Requirements
- R1: While select is low, each rising serial-clock edge shifts in one bit, MSB (bit 8) first. Every ninth bit completes a word, so several words may follow each other within one selection. A word with bit 8 = 0 is a command; a word with bit 8 = 1 is data whose byte is bits 7:0.
- R2: Command 0x10 sets `sleep_o`, and command 0x11 clears it.
- R3: Command 0x29 sets `disp_on_o`, and command 0x28 clears it.
- R4: A command code c in 0xB0..0xED selects register index c-0xB0. That register appears on `regs_o[(c-0xB0)*16 +: 16]`.
- R5: For a one-byte register, the first data byte after the command is written to bits 7:0, and bits 15:8 stay zero.
- R6: The two-byte registers are 0xB8, 0xC3 to 0xC7, 0xD0, 0xD2 to 0xD4 and 0xEC. For these, the first data byte goes to bits 15:8 and the second to bits 7:0.
- R7: Data bytes beyond a register's width (a second byte for a one-byte register, a third byte for a two-byte register) change nothing.
- R8: A data word changes nothing in each of these cases: it arrives after reset with no command yet; it follows a command outside 0xB0..0xED; or it arrives in a new selection, because raising select drops the current register selection.
- R9: Raising select after 1 to 8 bits of an unfinished word discards those bits and sets `frame_err_o`. The flag stays set until reset, and later complete words are still accepted.
- R10: After reset, `sleep_o` = 1, `disp_on_o` = 0, `frame_err_o` = 0 and every register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 4x the serial clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| spi_sclk_i | input | 1 | Serial clock, idles high, data sampled on rising edge |
| spi_mosi_i | input | 1 | Serial data in |
| spi_csn_i | input | 1 | Active-low select |
| regs_o | output | 992 | Register file, 16 bits per register, index 0 in bits 15:0 |
| sleep_o | output | 1 | Panel is in sleep |
| disp_on_o | output | 1 | Display is enabled |
| frame_err_o | output | 1 | Sticky flag: a partial word was cut off by deselect |

## Verification
Directed frames exercise the special cases. These include one- and two-byte register fills with surplus bytes, and data sent with no command. They also cover data after an out-of-range command and data in a fresh selection. Finally, a 5-bit partial word is sent, followed by a good frame, which shows that the error flag is sticky but does not block later words. These frames separate byte ordering, width limits and selection loss from one another.

Seeded random frames then mix state commands, window commands, out-of-window codes and stray leading data words, with zero to three data bytes each. After every frame, all registers and flags are compared with a bench model. This catches wrong index arithmetic, wrong two-byte membership and state commands that leak into the register file.

// File: rtl/spi9_pkg.sv
package spi9_pkg;
    localparam int WORD_W = 9;
    typedef logic [WORD_W-1:0] word_t;

    localparam logic [7:0] OP_SLEEP_ENTER = 8'h10;
    localparam logic [7:0] OP_SLEEP_LEAVE = 8'h11;
    localparam logic [7:0] OP_DISP_OFF    = 8'h28;
    localparam logic [7:0] OP_DISP_ON     = 8'h29;

    // one bit per register offset from the window base: set = two data bytes
    localparam logic [63:0] WIDE_DEFAULT = 64'h1000_001D_00F8_0100;
endpackage

// File: rtl/spi9_sync.sv
module spi9_sync #(
    parameter int          N_SIG   = 3,
    parameter int          STAGES  = 2,
    parameter logic [N_SIG-1:0] IDLE_VAL = '0
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [N_SIG-1:0] async_i,
    output logic [N_SIG-1:0] sync_o
);
    logic [STAGES-1:0][N_SIG-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int s = 0; s < STAGES; s++) begin
                chain_q[s] <= IDLE_VAL;
            end
        end else begin
            chain_q <= chain_d;
        end
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/spi9_shifter.sv
module spi9_shifter
    import spi9_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_ni,
    input  logic  sclk_s_i,
    input  logic  mosi_s_i,
    input  logic  csn_s_i,
    output logic  word_vld_o,
    output word_t word_o,
    output logic  frame_err_o
);
    localparam int CNT_W = $clog2(WORD_W + 1);

    typedef struct packed {
        logic                sclk_prev;
        logic [CNT_W-1:0]    cnt;
        logic [WORD_W-2:0]   sh;
        word_t               word;
        logic                vld;
        logic                ferr;
    } shf_t;

    shf_t st_d, st_q;
    logic rise;

    assign rise = sclk_s_i & ~st_q.sclk_prev;

    always_comb begin
        st_d           = st_q;
        st_d.sclk_prev = sclk_s_i;
        st_d.vld       = 1'b0;
        if (csn_s_i) begin
            if (st_q.cnt != '0) begin
                st_d.ferr = 1'b1;
            end
            st_d.cnt = '0;
        end else if (rise) begin
            if (st_q.cnt == CNT_W'(WORD_W - 1)) begin
                st_d.word = {st_q.sh, mosi_s_i};
                st_d.vld  = 1'b1;
                st_d.cnt  = '0;
            end else begin
                st_d.sh  = {st_q.sh[WORD_W-3:0], mosi_s_i};
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q           <= '0;
            st_q.sclk_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_vld_o  = st_q.vld;
    assign word_o      = st_q.word;
    assign frame_err_o = st_q.ferr;
endmodule

// File: rtl/spi9_decoder.sv
module spi9_decoder
    import spi9_pkg::*;
#(
    parameter int          REG_LO    = 8'hB0,
    parameter int          REG_HI    = 8'hED,
    parameter logic [63:0] WIDE_MASK = WIDE_DEFAULT,
    localparam int         NUM_REGS  = REG_HI - REG_LO + 1,
    localparam int         IDX_W     = $clog2(NUM_REGS)
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    word_vld_i,
    input  word_t                   word_i,
    input  logic                    desel_i,
    output logic [NUM_REGS*16-1:0]  regs_o,
    output logic                    sleep_o,
    output logic                    disp_on_o
);
    typedef struct packed {
        logic [NUM_REGS-1:0][15:0] regs;
        logic [IDX_W-1:0]          sel;
        logic                      sel_ok;
        logic [1:0]                nbytes;
        logic                      sleep;
        logic                      disp;
    } dec_t;

    dec_t st_d, st_q;
    logic [7:0] code;
    logic       in_window;
    logic       wide;

    assign code      = word_i[7:0];
    assign in_window = (int'(code) >= REG_LO) && (int'(code) <= REG_HI);
    assign wide      = WIDE_MASK[st_q.sel];

    always_comb begin
        st_d = st_q;
        if (word_vld_i) begin
            if (!word_i[8]) begin
                unique case (code)
                    OP_SLEEP_ENTER: st_d.sleep = 1'b1;
                    OP_SLEEP_LEAVE: st_d.sleep = 1'b0;
                    OP_DISP_ON:     st_d.disp  = 1'b1;
                    OP_DISP_OFF:    st_d.disp  = 1'b0;
                    default: ;
                endcase
                st_d.sel_ok = in_window;
                st_d.sel    = IDX_W'(int'(code) - REG_LO);
                st_d.nbytes = '0;
            end else if (st_q.sel_ok) begin
                if (wide && st_q.nbytes == 2'd0) begin
                    st_d.regs[st_q.sel][15:8] = code;
                end else if (wide && st_q.nbytes == 2'd1) begin
                    st_d.regs[st_q.sel][7:0] = code;
                end else if (!wide && st_q.nbytes == 2'd0) begin
                    st_d.regs[st_q.sel][7:0] = code;
                end
                if (st_q.nbytes != 2'd3) begin
                    st_d.nbytes = st_q.nbytes + 1'b1;
                end
            end
        end
        if (desel_i) begin
            st_d.sel_ok = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q       <= '0;
            st_q.sleep <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign regs_o    = st_q.regs;
    assign sleep_o   = st_q.sleep;
    assign disp_on_o = st_q.disp;
endmodule

// File: rtl/spi9_panel_regs.sv
module spi9_panel_regs
    import spi9_pkg::*;
#(
    parameter int          REG_LO      = 8'hB0,
    parameter int          REG_HI      = 8'hED,
    parameter int          SYNC_STAGES = 2,
    parameter logic [63:0] WIDE_MASK   = WIDE_DEFAULT,
    localparam int         NUM_REGS    = REG_HI - REG_LO + 1
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic                   spi_sclk_i,
    input  logic                   spi_mosi_i,
    input  logic                   spi_csn_i,
    output logic [NUM_REGS*16-1:0] regs_o,
    output logic                   sleep_o,
    output logic                   disp_on_o,
    output logic                   frame_err_o
);
    logic [2:0] pins_s;
    logic       word_vld;
    word_t      word;

    // pin order: {select, data, clock}; idle values select=1, clock=1
    spi9_sync #(
        .N_SIG   (3),
        .STAGES  (SYNC_STAGES),
        .IDLE_VAL(3'b101)
    ) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .async_i({spi_csn_i, spi_mosi_i, spi_sclk_i}),
        .sync_o (pins_s)
    );

    spi9_shifter u_shf (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .sclk_s_i   (pins_s[0]),
        .mosi_s_i   (pins_s[1]),
        .csn_s_i    (pins_s[2]),
        .word_vld_o (word_vld),
        .word_o     (word),
        .frame_err_o(frame_err_o)
    );

    spi9_decoder #(
        .REG_LO   (REG_LO),
        .REG_HI   (REG_HI),
        .WIDE_MASK(WIDE_MASK)
    ) u_dec (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .word_vld_i(word_vld),
        .word_i    (word),
        .desel_i   (pins_s[2]),
        .regs_o    (regs_o),
        .sleep_o   (sleep_o),
        .disp_on_o (disp_on_o)
    );
endmodule

// File: rtl/spi9_panel_regs_chk.sv
module spi9_panel_regs_chk #(
    parameter int REGS_W = 992
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              word_vld,
    input logic [8:0]        word,
    input logic [REGS_W-1:0] regs_o,
    input logic              sleep_o,
    input logic              disp_on_o,
    input logic              frame_err_o
);
    logic out_of_reset_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) out_of_reset_q <= 1'b0;
        else         out_of_reset_q <= 1'b1;
    end

    p_reset_state_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !out_of_reset_q |-> (sleep_o && !disp_on_o && !frame_err_o && regs_o == '0));

    p_sleep_enter_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (word_vld && word == 9'h010) |=> sleep_o);

    p_sleep_leave_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (word_vld && word == 9'h011) |=> !sleep_o);

    p_disp_on_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (word_vld && word == 9'h029) |=> disp_on_o);

    p_disp_off_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (word_vld && word == 9'h028) |=> !disp_on_o);

    p_regs_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (out_of_reset_q && !word_vld) |=> $stable(regs_o));

    p_cmd_no_reg_write_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (out_of_reset_q && word_vld && !word[8]) |=> $stable(regs_o));

    p_ferr_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        frame_err_o |=> frame_err_o);
endmodule

bind spi9_panel_regs spi9_panel_regs_chk #(.REGS_W(NUM_REGS*16)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .word_vld   (word_vld),
    .word       (word),
    .regs_o     (regs_o),
    .sleep_o    (sleep_o),
    .disp_on_o  (disp_on_o),
    .frame_err_o(frame_err_o)
);

// File: tb/spi9_panel_regs_tb.sv
module spi9_panel_regs_tb;
    localparam int NREG = 62;
    localparam int HALF = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b1, mosi = 1'b0, csn = 1'b1;
    logic [NREG*16-1:0] regs;
    logic sleep, disp, ferr;

    int n_chk = 0, n_fail = 0;
    logic [15:0] m_regs [NREG];
    logic        m_sel_ok, m_sleep, m_disp, m_ferr;
    int          m_sel, m_n;

    always #5 clk = ~clk;

    spi9_panel_regs u_dut (
        .clk_i(clk), .rst_ni(rst_n), .spi_sclk_i(sclk), .spi_mosi_i(mosi),
        .spi_csn_i(csn), .regs_o(regs), .sleep_o(sleep), .disp_on_o(disp),
        .frame_err_o(ferr)
    );

    function automatic bit is_wide(int c);
        return c == 8'hB8 || (c >= 8'hC3 && c <= 8'hC7) || c == 8'hD0 ||
               (c >= 8'hD2 && c <= 8'hD4) || c == 8'hEC;
    endfunction

    task automatic model_word(input logic [8:0] w);
        int c = int'(w[7:0]);
        if (!w[8]) begin
            if (c == 8'h10) m_sleep = 1'b1;
            if (c == 8'h11) m_sleep = 1'b0;
            if (c == 8'h29) m_disp = 1'b1;
            if (c == 8'h28) m_disp = 1'b0;
            m_sel_ok = (c >= 8'hB0 && c <= 8'hED);
            m_sel = c - 8'hB0;
            m_n = 0;
        end else if (m_sel_ok) begin
            if (is_wide(m_sel + 8'hB0)) begin
                if (m_n == 0) m_regs[m_sel][15:8] = w[7:0];
                if (m_n == 1) m_regs[m_sel][7:0]  = w[7:0];
            end else if (m_n == 0) begin
                m_regs[m_sel][7:0] = w[7:0];
            end
            m_n++;
        end
    endtask

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        int bad = -1;
        for (int i = 0; i < NREG; i++)
            if (bad < 0 && regs[i*16 +: 16] !== m_regs[i]) bad = i;
        n_chk++;
        if (bad >= 0) begin
            n_fail++;
            $display("FAIL %s reg %0h: actual %0h expected %0h", tag, bad + 8'hB0,
                     regs[bad*16 +: 16], m_regs[bad]);
        end
        check({tag, " R2 sleep"}, int'(sleep), int'(m_sleep));
        check({tag, " R3 disp"}, int'(disp), int'(m_disp));
        check({tag, " R9 ferr"}, int'(ferr), int'(m_ferr));
    endtask

    task automatic send_bits(input logic [8:0] w, input int nbits);
        for (int b = 8; b > 8 - nbits; b--) begin
            sclk = 1'b0; mosi = w[b];
            repeat (HALF) @(negedge clk);
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
        end
    endtask

    // one selection carrying whole words; model applied alongside
    task automatic frame(input logic [8:0] ws [$]);
        csn = 1'b0;
        repeat (HALF) @(negedge clk);
        foreach (ws[k]) begin
            send_bits(ws[k], 9);
            model_word(ws[k]);
        end
        repeat (HALF) @(negedge clk);
        csn = 1'b1;
        m_sel_ok = 1'b0;
        repeat (12) @(negedge clk);
    endtask

    initial begin
        logic [8:0] q [$];
        void'($urandom(32'h5A17));
        foreach (m_regs[i]) m_regs[i] = '0;
        m_sel_ok = 0; m_sleep = 1; m_disp = 0; m_ferr = 0; m_sel = 0; m_n = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check_all("R10 reset");

        q = '{9'h155};                          frame(q); check_all("R8 data before command");
        q = '{9'h011, 9'h029};                  frame(q); check_all("R1 back-to-back R2 R3");
        q = '{9'h0B0, 9'h117, 9'h1AA};          frame(q); check_all("R5 R7 narrow reg");
        check("R5 narrow hi zero", int'(regs[15:8]), 0);
        q = '{9'h0B8, 9'h1FF, 9'h1F9, 9'h112};  frame(q); check_all("R6 R7 wide reg");
        check("R6 wide value", int'(regs[8*16 +: 16]), 16'hFFF9);
        q = '{9'h155};                          frame(q); check_all("R8 selection lost on deselect");
        q = '{9'h03A, 9'h160};                  frame(q); check_all("R8 out-of-window command");
        q = '{9'h0ED, 9'h1C3};                  frame(q); check_all("R4 top of window");
        check("R4 index", int'(regs[61*16 +: 16]), 16'h00C3);
        q = '{9'h010, 9'h028};                  frame(q); check_all("R2 R3 off");

        for (int f = 0; f < 150; f++) begin
            int sel = $urandom_range(0, 7);
            int nd  = $urandom_range(0, 3);
            q = {};
            if ($urandom_range(0, 9) == 0) q.push_back({1'b1, 8'($urandom)});
            if (sel < 2)      q.push_back({1'b0, 8'({8'h10, 8'h11, 8'h28, 8'h29}[$urandom_range(0,3)*8 +: 8])});
            else if (sel < 6) q.push_back({1'b0, 8'($urandom_range(8'hB0, 8'hED))});
            else              q.push_back({1'b0, 8'($urandom)});
            for (int d = 0; d < nd; d++) q.push_back({1'b1, 8'($urandom)});
            frame(q);
            check_all("R1 R4 random frame");
        end

        csn = 1'b0;
        repeat (HALF) @(negedge clk);
        send_bits(9'h1A5, 5);
        csn = 1'b1;
        m_ferr = 1'b1;
        repeat (12) @(negedge clk);
        check_all("R9 partial word");
        q = '{9'h0C3, 9'h120, 9'h140};          frame(q); check_all("R9 sticky, words still accepted");
        check("R6 R9 after error", int'(regs[19*16 +: 16]), 16'h2040);

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule